// File: doc/BRIEF.md
# Operating-Point Hopping Selector

This block decides how a processing element runs a task so that it meets a frequency target within a deadline. It draws on a table of power-optimal operating points. Each point is a frequency in MHz, a discrete supply level index (four levels: 0.7, 0.9, 1.1 and 1.3 V) and a body-bias code. When the requested frequency is itself a table point, that point is applied for the whole deadline.

When the requested frequency lies between two table points, the block splits the deadline between the two neighbours so that the average frequency equals the request. First it computes a fixed-point weight α with a sequential divider. It then issues the faster neighbour for (1−α) of the deadline, followed by the slower neighbour for α of it. Every configuration change goes out on a valid/ready handshake. The phase timer starts only once the actuator side has accepted the change.

Requests above the fastest table point run at the fastest point and raise a range flag. Requests below the slowest point run at the slowest point.

Top module: `hop_selector`

## Requirements
- R1: During and right after reset, `req_ready_o` is 1, and both `cfg_valid_o` and `done_o` are 0.
- R2: If the target equals the frequency of a valid entry, that single entry is issued. Its phase lasts the whole deadline, and `hop_o` and `alpha_o` read 0.
- R3: If the target lies strictly between valid entries k−1 and k, entry k (higher frequency) is issued first, then entry k−1. `hop_o` reads 1.
- R4: In the R3 case, `alpha_o` equals floor((F[k]−T)·256/(F[k]−F[k−1])), an 8-bit value.
- R5: In the R3 case, the lower phase lasts floor(alpha·DL/256) cycles and the higher phase lasts DL minus that. A lower phase of zero length is not issued.
- R6: If the target exceeds the frequency of the last valid entry, only that entry is issued for the whole deadline, and `out_of_range_o` reads 1.
- R7: If the target is below entry 0, only entry 0 is issued for the whole deadline, and `out_of_range_o` reads 0.
- R8: While `cfg_valid_o` is high and `cfg_ready_i` is low, the configuration outputs stay unchanged. A phase of D cycles begins at the clock edge that completes the handshake. The next `cfg_valid_o`, or `done_o`, appears D cycles after that edge.
- R9: `done_o` is a one-cycle pulse raised when the last phase ends, together with the return of `req_ready_o`. A deadline of 0 is treated as 1 cycle.
- R10: Only entries below `tbl_count_i` (range 1..16) take part in the search. Entries at or past the count are ignored. Valid entries have strictly rising frequencies. Entry i takes bits [12i+11:12i] of `tbl_freq_i`, [2i+1:2i] of `tbl_vsel_i` and [8i+7:8i] of `tbl_bb_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_freq_i | input | 192 | Packed entry frequencies in MHz, 12 bits per entry |
| tbl_vsel_i | input | 32 | Packed supply level indices, 2 bits per entry |
| tbl_bb_i | input | 128 | Packed body-bias codes, 8 bits per entry |
| tbl_count_i | input | 5 | Number of valid entries |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Idle, request accepted |
| req_freq_i | input | 12 | Target frequency in MHz |
| req_deadline_i | input | 24 | Deadline in clock cycles |
| cfg_valid_o | output | 1 | Configuration change offered |
| cfg_ready_i | input | 1 | Actuators accept the change |
| cfg_vsel_o | output | 2 | Supply level index |
| cfg_bb_o | output | 8 | Body-bias code |
| cfg_freq_o | output | 12 | Frequency in MHz |
| hop_o | output | 1 | Current request splits between two points |
| alpha_o | output | 8 | Weight of the lower point, in units of 1/256 |
| out_of_range_o | output | 1 | Target above the fastest valid entry |
| done_o | output | 1 | Deadline fully sequenced |

## Verification
The assertions check, on every cycle, the properties that hold regardless of table contents:
- Stalled configuration offers stay stable.
- The phase timer never advances while a change is still being offered.
- `done_o` is a single-cycle pulse that coincides with the return to idle.
- The block never offers a change while it is idle.
- A saturated request never hops.

Only the bench scenarios can show which entries are picked, the value of α, and the exact split of the deadline between the phases. These depend on arithmetic over the table. Examples include:
- the skipped zero-length lower phase;
- the near-boundary targets;
- a padded entry beyond the count that would otherwise match.

// File: rtl/hop_pkg.sv
package hop_pkg;
  localparam int FREQ_W = 12;
  localparam int BB_W   = 8;
  localparam int VS_W   = 2;
  localparam int FRAC_W = 8;
  localparam int DL_W   = 24;

  typedef struct packed {
    logic [VS_W-1:0]   vsel;
    logic [BB_W-1:0]   bb;
    logic [FREQ_W-1:0] freq;
  } op_point_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRCH, ST_DIV, ST_ISSUE_A, ST_RUN_A, ST_ISSUE_B, ST_RUN_B
  } hop_state_t;

  // cycles given to the lower point: floor(alpha * dl / 2^FRAC_W)
  function automatic logic [DL_W-1:0] low_share(input logic [FRAC_W-1:0] alpha,
                                                 input logic [DL_W-1:0]   dl);
    logic [DL_W+FRAC_W-1:0] prod;
    prod = {{DL_W{1'b0}}, alpha} * {{FRAC_W{1'b0}}, dl};
    return prod[DL_W+FRAC_W-1:FRAC_W];
  endfunction

  // a zero deadline still holds the point for one cycle
  function automatic logic [DL_W-1:0] eff_deadline(input logic [DL_W-1:0] dl);
    return (dl == '0) ? DL_W'(1) : dl;
  endfunction
endpackage

// File: rtl/hop_search.sv
module hop_search
  import hop_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int CNT_W = $clog2(N_ENTRIES + 1)
) (
  input  op_point_t         tbl [N_ENTRIES],
  input  logic [CNT_W-1:0]  count,
  input  logic [FREQ_W-1:0] target,
  output logic [IDX_W-1:0]  hi_idx,
  output logic [IDX_W-1:0]  lo_idx,
  output logic              single,
  output logic              above
);
  always_comb begin
    logic found;
    found  = 1'b0;
    hi_idx = IDX_W'(count - CNT_W'(1));
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!found && (CNT_W'(i) < count) && (tbl[i].freq >= target)) begin
        found  = 1'b1;
        hi_idx = IDX_W'(i);
      end
    end
    above  = !found;
    single = !found || (hi_idx == '0) || (tbl[hi_idx].freq == target);
    lo_idx = hi_idx - IDX_W'(1);
  end
endmodule

// File: rtl/hop_divider.sv
module hop_divider #(
  parameter int NUM_W = 12,
  parameter int Q_W   = 8,
  localparam int CNT_W = $clog2(Q_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);
  // restoring fraction divider, requires num < den
  logic [NUM_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [NUM_W:0]   rem_sh;
  logic             take;

  assign rem_sh = {rem_q, 1'b0};
  assign take   = rem_sh >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        rem_q  <= num;
        quot_o <= '0;
        cnt_q  <= CNT_W'(Q_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= take ? NUM_W'(rem_sh - {1'b0, den}) : rem_sh[NUM_W-1:0];
        quot_o <= {quot_o[Q_W-2:0], take};
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hop_selector.sv
module hop_selector
  import hop_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int CNT_W = $clog2(N_ENTRIES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_ENTRIES*FREQ_W-1:0] tbl_freq_i,
  input  logic [N_ENTRIES*VS_W-1:0]   tbl_vsel_i,
  input  logic [N_ENTRIES*BB_W-1:0]   tbl_bb_i,
  input  logic [CNT_W-1:0]            tbl_count_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [FREQ_W-1:0]           req_freq_i,
  input  logic [DL_W-1:0]             req_deadline_i,
  output logic                        cfg_valid_o,
  input  logic                        cfg_ready_i,
  output logic [VS_W-1:0]             cfg_vsel_o,
  output logic [BB_W-1:0]             cfg_bb_o,
  output logic [FREQ_W-1:0]           cfg_freq_o,
  output logic                        hop_o,
  output logic [FRAC_W-1:0]           alpha_o,
  output logic                        out_of_range_o,
  output logic                        done_o
);
  op_point_t tbl [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_unpack
    assign tbl[g].freq = tbl_freq_i[g*FREQ_W +: FREQ_W];
    assign tbl[g].vsel = tbl_vsel_i[g*VS_W +: VS_W];
    assign tbl[g].bb   = tbl_bb_i[g*BB_W +: BB_W];
  end

  hop_state_t        state_q;
  logic [FREQ_W-1:0] tgt_q;
  logic [DL_W-1:0]   dl_q, dur_a_q, dur_b_q, cnt_q;
  logic [IDX_W-1:0]  hi_q, lo_q, cur_idx_q;
  logic              hop_q, oor_q, done_q;
  logic [FRAC_W-1:0] alpha_q;

  logic [IDX_W-1:0]  s_hi, s_lo;
  logic              s_single, s_above;
  logic              div_start, div_done;
  logic [FRAC_W-1:0] div_q;
  logic [FREQ_W-1:0] div_num, div_den;
  logic [DL_W-1:0]   lo_cycles;

  // events brought out for the checker
  logic              phase_tick, phase_last, cfg_fire;

  hop_search #(.N_ENTRIES(N_ENTRIES)) i_search (
    .tbl    (tbl),
    .count  (tbl_count_i),
    .target (tgt_q),
    .hi_idx (s_hi),
    .lo_idx (s_lo),
    .single (s_single),
    .above  (s_above)
  );

  assign div_num   = tbl[s_hi].freq - tgt_q;
  assign div_den   = tbl[s_hi].freq - tbl[s_lo].freq;
  assign div_start = (state_q == ST_SRCH) && !s_single;

  hop_divider #(.NUM_W(FREQ_W), .Q_W(FRAC_W)) i_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (div_start),
    .num    (div_num),
    .den    (div_den),
    .done_o (div_done),
    .quot_o (div_q)
  );

  assign lo_cycles  = low_share(div_q, dl_q);
  assign phase_tick = (state_q == ST_RUN_A) || (state_q == ST_RUN_B);
  assign phase_last = phase_tick && (cnt_q == DL_W'(1));
  assign cfg_fire   = cfg_valid_o && cfg_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      dl_q      <= '0;
      dur_a_q   <= '0;
      dur_b_q   <= '0;
      cnt_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      cur_idx_q <= '0;
      hop_q     <= 1'b0;
      oor_q     <= 1'b0;
      alpha_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          tgt_q   <= req_freq_i;
          dl_q    <= eff_deadline(req_deadline_i);
          state_q <= ST_SRCH;
        end
        ST_SRCH: begin
          hi_q  <= s_hi;
          lo_q  <= s_lo;
          hop_q <= !s_single;
          oor_q <= s_above;
          if (s_single) begin
            alpha_q   <= '0;
            dur_a_q   <= dl_q;
            dur_b_q   <= '0;
            cur_idx_q <= s_hi;
            state_q   <= ST_ISSUE_A;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          alpha_q   <= div_q;
          dur_b_q   <= lo_cycles;
          dur_a_q   <= dl_q - lo_cycles;
          cur_idx_q <= hi_q;
          state_q   <= ST_ISSUE_A;
        end
        ST_ISSUE_A: if (cfg_ready_i) begin
          cnt_q   <= dur_a_q;
          state_q <= ST_RUN_A;
        end
        ST_RUN_A: begin
          cnt_q <= cnt_q - DL_W'(1);
          if (phase_last) begin
            if (hop_q && (dur_b_q != '0)) begin
              cur_idx_q <= lo_q;
              state_q   <= ST_ISSUE_B;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ISSUE_B: if (cfg_ready_i) begin
          cnt_q   <= dur_b_q;
          state_q <= ST_RUN_B;
        end
        ST_RUN_B: begin
          cnt_q <= cnt_q - DL_W'(1);
          if (phase_last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign cfg_valid_o    = (state_q == ST_ISSUE_A) || (state_q == ST_ISSUE_B);
  assign cfg_vsel_o     = tbl[cur_idx_q].vsel;
  assign cfg_bb_o       = tbl[cur_idx_q].bb;
  assign cfg_freq_o     = tbl[cur_idx_q].freq;
  assign hop_o          = hop_q;
  assign alpha_o        = alpha_q;
  assign out_of_range_o = oor_q;
  assign done_o         = done_q;
endmodule

// File: rtl/hop_selector_chk.sv
module hop_selector_chk
  import hop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [VS_W-1:0]   cfg_vsel,
  input logic [BB_W-1:0]   cfg_bb,
  input logic [FREQ_W-1:0] cfg_freq,
  input logic              phase_tick,
  input logic              hop,
  input logic              oor,
  input logic              done
);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_vsel) && $stable(cfg_bb) && $stable(cfg_freq));

  // R8
  tick_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> !cfg_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cfg_valid);

  // R6
  oor_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && oor |-> !hop);
endmodule

bind hop_selector hop_selector_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready_o),
  .cfg_valid  (cfg_valid_o),
  .cfg_ready  (cfg_ready_i),
  .cfg_vsel   (cfg_vsel_o),
  .cfg_bb     (cfg_bb_o),
  .cfg_freq   (cfg_freq_o),
  .phase_tick (phase_tick),
  .hop        (hop_o),
  .oor        (out_of_range_o),
  .done       (done_o)
);

// File: tb/test_hop_selector.sv
module test_hop_selector;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N*12-1:0] tbl_freq_i;
  logic [N*2-1:0]  tbl_vsel_i;
  logic [N*8-1:0]  tbl_bb_i;
  logic [4:0]    tbl_count_i;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [11:0]   req_freq_i = '0;
  logic [23:0]   req_deadline_i = '0;
  logic          cfg_valid_o;
  logic          cfg_ready_i = 1'b1;
  logic [1:0]    cfg_vsel_o;
  logic [7:0]    cfg_bb_o;
  logic [11:0]   cfg_freq_o;
  logic          hop_o;
  logic [7:0]    alpha_o;
  logic          out_of_range_o;
  logic          done_o;

  hop_selector i_hop_selector (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int vsel; int bb; int freq; int dur; int hop; int alpha; int oor; string tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit stall_mode = 0;
  bit finished = 0;
  int bf[8] = '{700, 900, 1100, 1300, 1600, 1900, 2200, 2560};

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) cfg_ready_i <= stall_mode ? ((cyc % 3) != 0) : 1'b1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  bit pend_on = 0; int pend_cyc = 0; item_t pend;
  bit prev_stall = 0; int sv_vsel, sv_bb, sv_freq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_on && (cfg_valid_o || done_o)) begin
        chk(cyc - pend_cyc - 1 == pend.dur, pend.tag, "phase length", cyc - pend_cyc - 1, pend.dur);
        pend_on = 0;
      end
      if (prev_stall) begin
        chk(cfg_valid_o && cfg_freq_o == sv_freq && cfg_vsel_o == sv_vsel && cfg_bb_o == sv_bb,
            "R8", "stalled freq", int'(cfg_freq_o), sv_freq);
      end
      prev_stall = cfg_valid_o && !cfg_ready_i;
      sv_vsel = cfg_vsel_o; sv_bb = cfg_bb_o; sv_freq = cfg_freq_o;
      if (cfg_valid_o && cfg_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected config, queue size", 1, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(cfg_freq_o == e.freq, e.tag, "freq", int'(cfg_freq_o), e.freq);
          chk(cfg_vsel_o == e.vsel && cfg_bb_o == e.bb, e.tag, "vsel*256+bb",
              int'(cfg_vsel_o) * 256 + int'(cfg_bb_o), e.vsel * 256 + e.bb);
          chk(hop_o == e.hop && out_of_range_o == e.oor, e.tag, "hop*2+oor",
              int'(hop_o) * 2 + int'(out_of_range_o), e.hop * 2 + e.oor);
          chk(alpha_o == e.alpha, (e.hop != 0) ? "R4" : e.tag, "alpha", int'(alpha_o), e.alpha);
          pend = e; pend_on = 1; pend_cyc = cyc;
        end
      end
      if (done_o) begin
        chk(exp_q.size() == 0 && req_ready_o, "R9", "phases left at done", exp_q.size(), 0);
        done_cnt++;
      end
    end
  end

  function automatic item_t mk(input int idx, input int dur, input int hop, input int alpha,
                               input int oor, input string tag);
    item_t it;
    it.vsel = idx / 2; it.bb = 10 * idx + 5; it.freq = bf[idx];
    it.dur = dur; it.hop = hop; it.alpha = alpha; it.oor = oor; it.tag = tag;
    return it;
  endfunction

  task automatic run_req(input int tgt, input int dl_in, input string tag);
    int hi = -1;
    int dl = (dl_in == 0) ? 1 : dl_in;
    int start_done = done_cnt;
    for (int i = 0; i < 8; i++) if (hi < 0 && bf[i] >= tgt) hi = i;
    if (hi < 0) exp_q.push_back(mk(7, dl, 0, 0, 1, tag));
    else if (bf[hi] == tgt || hi == 0) exp_q.push_back(mk(hi, dl, 0, 0, 0, tag));
    else begin
      int a = ((bf[hi] - tgt) * 256) / (bf[hi] - bf[hi-1]);
      int tlo = (a * dl) / 256;
      exp_q.push_back(mk(hi, dl - tlo, 1, a, 0, tag));
      if (tlo > 0) exp_q.push_back(mk(hi - 1, tlo, 1, a, 0, tag));
    end
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R9", "ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1; req_freq_i = 12'(tgt); req_deadline_i = 24'(dl_in);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (done_cnt == start_done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      if (i < 8) begin
        tbl_freq_i[i*12 +: 12] = 12'(bf[i]);
        tbl_vsel_i[i*2 +: 2]   = 2'(i / 2);
        tbl_bb_i[i*8 +: 8]     = 8'(10 * i + 5);
      end else begin
        tbl_freq_i[i*12 +: 12] = 12'd1000;  // padding beyond count (R10)
        tbl_vsel_i[i*2 +: 2]   = 2'd3;
        tbl_bb_i[i*8 +: 8]     = 8'hEE;
      end
    end
    tbl_count_i = 5'd8;
    repeat (3) @(negedge clk);
    chk(req_ready_o && !cfg_valid_o && !done_o, "R1", "reset ready/valid/done",
        {req_ready_o, cfg_valid_o, done_o}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !cfg_valid_o && !done_o, "R1", "post-reset ready/valid/done",
        {req_ready_o, cfg_valid_o, done_o}, 4);
    run_req(1100, 20, "R2");
    run_req(1000, 40, "R10");   // hop 1100/900; padded 1000 entry ignored
    run_req(1600, 13, "R2");
    stall_mode = 1;
    run_req(2500, 100, "R8");   // hop under stalls
    stall_mode = 0;
    run_req(3000, 10, "R6");
    run_req(500, 7, "R7");
    run_req(2559, 3, "R5");     // alpha 0, lower phase skipped
    run_req(701, 50, "R3");     // higher 1 cycle, lower 49
    run_req(1300, 0, "R9");     // zero deadline -> 1 cycle
    run_req(1450, 1, "R5");
    run_req(2560, 9, "R2");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "leftover expected items", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", done_cnt, 11);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule